// File: doc/BRIEF.md
# Register-Conditional Branch Resolver

This unit resolves a branch whose decision depends on the contents of a general register rather than on condition flags. Each cycle it may accept one 32-bit instruction word together with the 64-bit value of the source register that the instruction names and the address of the instruction. It checks whether the word uses the register-branch format. It rebuilds the 16-bit word displacement from its two separated fields and compares the register, read as a signed 64-bit number, against zero. It then reports whether the branch is taken, the target address, whether the delay-slot instruction must be squashed, and the static direction hint carried in the word.

All results are registered, so they appear one clock after the word is presented. The branch has one delay slot: when the condition holds, the instruction after the delay slot comes from the target. Condition codes that are not defined, and words whose must-be-zero bit is set, are reported as illegal and never produce a taken branch. Fetch, register read, pipeline redirection and flag-based branches are handled elsewhere.

Top module: `brr_resolver`

## Requirements
- R1: While rst_n is low at a rising clock edge, every output is driven to zero on that edge, whatever the inputs are.
- R2: out_valid_o equals in_valid_i delayed by exactly one clock, and all other outputs describe the word presented on that earlier clock.
- R3: is_brr_o is 1 only for a valid word whose bits 31:30 are 00 and whose bits 24:22 are 011; otherwise is_brr_o, taken_o, annul_o, hint_o and illegal_o are all 0.
- R4: For a recognised word with a defined condition in bits 27:25, taken_o follows the register value as a signed 64-bit number: 1 means equal to zero, 2 means at most zero, 3 means below zero, 5 means not zero, 6 means above zero, 7 means at least zero.
- R5: Condition codes 0 and 4 set illegal_o and keep taken_o, annul_o and hint_o at 0.
- R6: A recognised word with bit 28 set raises illegal_o and keeps taken_o, annul_o and hint_o at 0, whatever the condition.
- R7: target_o equals the instruction address plus four times the sign-extended 16-bit displacement, whose upper two bits are word bits 21:20 and whose lower fourteen bits are word bits 13:0, with the sum wrapping at 64 bits.
- R8: annul_o is 1 exactly when a legal recognised branch is not taken and its bit 29 is 1; a taken branch never annuls its delay slot.
- R9: hint_o repeats word bit 19 (1 means predict taken) for a legal recognised branch, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | A word is presented this cycle |
| insn_i | input | 32 | Instruction word |
| reg_val_i | input | 64 | Value of the source register |
| pc_i | input | 64 | Address of the instruction |
| out_valid_o | output | 1 | Results below belong to a presented word |
| is_brr_o | output | 1 | The word uses the register-branch format |
| taken_o | output | 1 | The branch goes to the target |
| target_o | output | 64 | Branch target address |
| annul_o | output | 1 | Squash the delay-slot instruction |
| hint_o | output | 1 | Static prediction: predict taken |
| illegal_o | output | 1 | Reserved condition or must-be-zero bit set |

## Verification
The hardest situations to reach are the sign boundaries of the comparison: the most negative 64-bit value, which only a full-width sign test classifies correctly, and the values zero, one and minus one, where equal, below and above meet. The stimulus crosses all eight condition codes with a fixed list of register values holding these extremes, the largest positive value, and values whose only set bit lies in an upper 16-bit chunk, with every combination of the annul and hint bits. Displacements with both sign polarities, including the two values where the upper field alone flips the sign, run against addresses near the 64-bit wrap point. Words with bit 28 set, foreign formats and idle cycles are mixed in, and a behavioural model checks every output on every clock.

// File: rtl/brr_pkg.sv
// Package brr_pkg
// Shared field positions, condition encoding and decoded-field record for
// the register-conditional branch resolver. Positions are fixed by the
// instruction format; only the datapath widths are parameters elsewhere.
package brr_pkg;

    localparam int INSN_W    = 32;
    localparam int DISP_W    = 16;
    localparam int DISP_HI_W = 2;
    localparam int DISP_LO_W = DISP_W - DISP_HI_W;

    // bit positions inside the instruction word
    localparam int POS_FMT_HI   = 31;
    localparam int POS_FMT_LO   = 30;
    localparam int POS_ANNUL    = 29;
    localparam int POS_MBZ      = 28;
    localparam int POS_COND_HI  = 27;
    localparam int POS_COND_LO  = 25;
    localparam int POS_OP2_HI   = 24;
    localparam int POS_OP2_LO   = 22;
    localparam int POS_DHI_HI   = 21;
    localparam int POS_DHI_LO   = 20;
    localparam int POS_HINT     = 19;
    localparam int POS_DLO_HI   = 13;

    // condition against zero
    typedef enum logic [2:0] {
        ZC_RSV_A = 3'd0,
        ZC_EQ    = 3'd1,
        ZC_LE    = 3'd2,
        ZC_LT    = 3'd3,
        ZC_RSV_B = 3'd4,
        ZC_NE    = 3'd5,
        ZC_GT    = 3'd6,
        ZC_GE    = 3'd7
    } zcond_e;

    // fields pulled out of one instruction word
    typedef struct packed {
        logic              fmt_hit;   // format and sub-opcode match
        logic              mbz_set;   // must-be-zero bit is one
        logic              annul;     // squash slot when not taken
        logic              hint;      // predict taken
        zcond_e            cond;      // comparison against zero
        logic [DISP_W-1:0] disp;      // reassembled word displacement
    } brr_fields_t;

endpackage

// File: rtl/brr_field_decode.sv
// Module brr_field_decode
// Purely combinational. Splits an instruction word into the fields the
// resolver needs and rebuilds the 16-bit displacement from its upper part
// (bits 21:20) and lower part (bits 13:0). Assumes the word is only
// meaningful when the caller also qualifies it with a valid strobe.
module brr_field_decode
    import brr_pkg::*;
#(
    parameter logic [2:0] OP2_SEL = 3'b011
) (
    input  logic [INSN_W-1:0] insn_i,
    output brr_fields_t       fld_o
);

    logic [1:0]           fmt_bits;
    logic [2:0]           op2_bits;
    logic [DISP_HI_W-1:0] disp_hi;
    logic [DISP_LO_W-1:0] disp_lo;

    // slice the raw bit groups out of the word
    always_comb begin
        fmt_bits = insn_i[POS_FMT_HI:POS_FMT_LO];
        op2_bits = insn_i[POS_OP2_HI:POS_OP2_LO];
        disp_hi  = insn_i[POS_DHI_HI:POS_DHI_LO];
        disp_lo  = insn_i[POS_DLO_HI:0];
    end

    // assemble the decoded record
    always_comb begin
        fld_o.fmt_hit = (fmt_bits == 2'b00) && (op2_bits == OP2_SEL);
        fld_o.mbz_set = insn_i[POS_MBZ];
        fld_o.annul   = insn_i[POS_ANNUL];
        fld_o.hint    = insn_i[POS_HINT];
        fld_o.cond    = zcond_e'(insn_i[POS_COND_HI:POS_COND_LO]);
        fld_o.disp    = {disp_hi, disp_lo};
    end

endmodule

// File: rtl/brr_zero_test.sv
// Module brr_zero_test
// Purely combinational. Compares a two's-complement register value with
// zero and evaluates the selected condition. The zero detect is built as a
// per-chunk OR followed by a final OR so its depth stays shallow for wide
// registers. Assumes DATA_W is a multiple of CHUNK_W.
module brr_zero_test
    import brr_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int CHUNK_W = 16
) (
    input  logic [DATA_W-1:0] val_i,
    input  zcond_e            cond_i,
    output logic              cond_ok_o,   // code is a defined condition
    output logic              cond_true_o  // defined condition holds
);

    localparam int N_CHUNK = DATA_W / CHUNK_W;

    logic [N_CHUNK-1:0] chunk_nz;
    logic               is_zero;
    logic               is_neg;

    // one OR reduction per chunk
    for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
        assign chunk_nz[g] = |val_i[g*CHUNK_W +: CHUNK_W];
    end

    // combine chunk results and take the sign
    always_comb begin
        is_zero = ~|chunk_nz;
        is_neg  = val_i[DATA_W-1];
    end

    // evaluate the selected condition
    always_comb begin
        cond_ok_o   = 1'b1;
        cond_true_o = 1'b0;
        unique case (cond_i)
            ZC_EQ:   cond_true_o = is_zero;
            ZC_LE:   cond_true_o = is_zero | is_neg;
            ZC_LT:   cond_true_o = is_neg;
            ZC_NE:   cond_true_o = ~is_zero;
            ZC_GT:   cond_true_o = ~is_zero & ~is_neg;
            ZC_GE:   cond_true_o = ~is_neg;
            default: cond_ok_o   = 1'b0;
        endcase
    end

endmodule

// File: rtl/brr_target_calc.sv
// Module brr_target_calc
// Purely combinational. Forms the branch target as the instruction address
// plus the sign-extended word displacement scaled to bytes. Assumes
// instructions are four bytes long; the sum wraps at ADDR_W bits.
module brr_target_calc
    import brr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - DISP_W - 2;

    logic [ADDR_W-1:0] byte_off;

    // sign-extend and scale the displacement
    always_comb begin
        byte_off = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 2'b00};
    end

    // add to the instruction address
    always_comb begin
        target_o = pc_i + byte_off;
    end

endmodule

// File: rtl/brr_resolver.sv
// Module brr_resolver
// Top of the register-conditional branch resolver. Decodes one word per
// cycle, evaluates its condition against the register value, computes the
// target and registers every result, so outputs follow inputs by one clock.
// Assumes reg_val_i is already the value of the register the word names.
// Reset is synchronous and active low.
module brr_resolver
    import brr_pkg::*;
#(
    parameter int         ADDR_W  = 64,
    parameter int         DATA_W  = 64,
    parameter int         CHUNK_W = 16,
    parameter logic [2:0] OP2_SEL = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [31:0]       insn_i,
    input  logic [DATA_W-1:0] reg_val_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              out_valid_o,
    output logic              is_brr_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              annul_o,
    output logic              hint_o,
    output logic              illegal_o
);

    brr_fields_t       fld;
    logic              cond_ok;
    logic              cond_true;
    logic [ADDR_W-1:0] tgt_d;

    logic              hit_d;
    logic              bad_d;
    logic              legal_d;
    logic              take_d;
    logic              annul_d;
    logic              hint_d;

    brr_field_decode #(.OP2_SEL(OP2_SEL)) u_dec (
        .insn_i (insn_i),
        .fld_o  (fld)
    );

    brr_zero_test #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_cmp (
        .val_i       (reg_val_i),
        .cond_i      (fld.cond),
        .cond_ok_o   (cond_ok),
        .cond_true_o (cond_true)
    );

    brr_target_calc #(.ADDR_W(ADDR_W)) u_tgt (
        .pc_i     (pc_i),
        .disp_i   (fld.disp),
        .target_o (tgt_d)
    );

    // qualify decoded fields and form the next-state flags
    always_comb begin
        hit_d   = in_valid_i & fld.fmt_hit;
        bad_d   = hit_d & (fld.mbz_set | ~cond_ok);
        legal_d = hit_d & ~bad_d;
        take_d  = legal_d & cond_true;
        annul_d = legal_d & ~cond_true & fld.annul;
        hint_d  = legal_d & fld.hint;
    end

    // output register stage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            is_brr_o    <= 1'b0;
            taken_o     <= 1'b0;
            target_o    <= '0;
            annul_o     <= 1'b0;
            hint_o      <= 1'b0;
            illegal_o   <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
            is_brr_o    <= hit_d;
            taken_o     <= take_d;
            target_o    <= tgt_d;
            annul_o     <= annul_d;
            hint_o      <= hint_d;
            illegal_o   <= bad_d;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid_o && !is_brr_o && !taken_o && !illegal_o));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    // R3
    flags_need_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o || annul_o || hint_o || illegal_o) |-> (is_brr_o && out_valid_o));

    // R5
    reserved_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!taken_o && !annul_o && !hint_o));

    // R8
    annul_excl_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(annul_o && taken_o));

    // R6
    mbz_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && fld.fmt_hit && insn_i[POS_MBZ]) |=> (illegal_o && !taken_o));

endmodule

// File: tb/tb_brr_resolver.sv
module tb_brr_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] reg_val_i = '0;
    logic [63:0] pc_i = '0;
    logic        out_valid_o, is_brr_o, taken_o, annul_o, hint_o, illegal_o;
    logic [63:0] target_o;

    int total = 0;
    int bad   = 0;

    // expected results for the word driven one clock earlier
    logic        have_exp = 1'b0;
    logic        e_val, e_brr, e_tak, e_ann, e_hint, e_ill;
    logic [63:0] e_tgt;

    always #10 clk = ~clk;

    brr_resolver dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .insn_i(insn_i),
        .reg_val_i(reg_val_i), .pc_i(pc_i), .out_valid_o(out_valid_o),
        .is_brr_o(is_brr_o), .taken_o(taken_o), .target_o(target_o),
        .annul_o(annul_o), .hint_o(hint_o), .illegal_o(illegal_o)
    );

    function automatic logic [31:0] mk(input logic [1:0] fmt, input logic a,
        input logic mbz, input logic [2:0] c, input logic [2:0] op2,
        input logic p, input logic [15:0] d);
        return {fmt, a, mbz, c, op2, d[15:14], p, 5'd3, d[13:0]};
    endfunction

    task automatic chk1(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // behavioural model of the requirements
    task automatic model(input logic v, input logic [31:0] w,
                         input logic [63:0] r, input logic [63:0] pc);
        longint  sv;
        shortint d;
        longint  off;
        bit      hold;
        bit      hit, ill;
        sv  = longint'(r);
        d   = shortint'({w[21:20], w[13:0]});
        off = longint'(d) * 4;
        hit = v && (w[31:30] == 2'b00) && (w[24:22] == 3'b011);
        case (w[27:25])
            3'd1: hold = (sv == 0);
            3'd2: hold = (sv <= 0);
            3'd3: hold = (sv < 0);
            3'd5: hold = (sv != 0);
            3'd6: hold = (sv > 0);
            3'd7: hold = (sv >= 0);
            default: hold = 1'b0;
        endcase
        ill    = hit && (w[28] || w[27:25] == 3'd0 || w[27:25] == 3'd4);
        e_val  = v;
        e_brr  = hit;
        e_ill  = ill;
        e_tak  = hit && !ill && hold;
        e_ann  = hit && !ill && !hold && w[29];
        e_hint = hit && !ill && w[19];
        e_tgt  = pc + 64'(off);
    endtask

    task automatic compare_now();
        if (!have_exp) return;
        chk1("R2 out_valid", 64'(out_valid_o), 64'(e_val));
        chk1("R3 is_brr",    64'(is_brr_o),    64'(e_brr));
        chk1("R4 taken",     64'(taken_o),     64'(e_tak));
        chk1("R5/R6 illegal",64'(illegal_o),   64'(e_ill));
        chk1("R7 target",    target_o,         e_tgt);
        chk1("R8 annul",     64'(annul_o),     64'(e_ann));
        chk1("R9 hint",      64'(hint_o),      64'(e_hint));
    endtask

    // one cycle: check previous word, then drive a new one
    task automatic step(input logic v, input logic [31:0] w,
                        input logic [63:0] r, input logic [63:0] pc);
        @(negedge clk);
        compare_now();
        in_valid_i = v; insn_i = w; reg_val_i = r; pc_i = pc;
        model(v, w, r, pc);
        have_exp = 1'b1;
    endtask

    task automatic run_all();
        logic [63:0] vals [10];
        logic [15:0] disps [6];
        vals[0] = 64'd0;                  vals[1] = 64'd1;
        vals[2] = 64'hFFFF_FFFF_FFFF_FFFF; vals[3] = 64'h8000_0000_0000_0000;
        vals[4] = 64'h7FFF_FFFF_FFFF_FFFF; vals[5] = 64'h0001_0000_0000_0000;
        vals[6] = 64'h0000_0000_0001_0000; vals[7] = 64'hFFFF_FFFF_0000_0000;
        vals[8] = 64'd5;                   vals[9] = 64'hFFFF_FFFF_FFFF_FFFB;
        disps[0] = 16'h0000; disps[1] = 16'h0001; disps[2] = 16'hFFFF;
        disps[3] = 16'h8000; disps[4] = 16'h7FFF; disps[5] = 16'h4000;

        // R1: reset dominates a live branch word
        in_valid_i = 1'b1;
        insn_i = mk(2'b00, 1'b1, 1'b0, 3'd1, 3'b011, 1'b1, 16'h0010);
        reg_val_i = '0; pc_i = 64'h1000;
        repeat (3) @(negedge clk);
        chk1("R1 out_valid", 64'(out_valid_o), 64'd0);
        chk1("R1 is_brr",    64'(is_brr_o),    64'd0);
        chk1("R1 taken",     64'(taken_o),     64'd0);
        chk1("R1 target",    target_o,         64'd0);
        chk1("R1 annul",     64'(annul_o),     64'd0);
        chk1("R1 hint",      64'(hint_o),      64'd0);
        chk1("R1 illegal",   64'(illegal_o),   64'd0);
        rst_n = 1'b1;
        in_valid_i = 1'b0;

        // R4 R5 R8 R9: every condition against every value, all flag combos
        for (int c = 0; c < 8; c++)
            for (int i = 0; i < 10; i++)
                for (int f = 0; f < 4; f++)
                    step(1'b1, mk(2'b00, f[0], 1'b0, 3'(c), 3'b011, f[1],
                                  disps[(c + i) % 6]),
                         vals[i], 64'h0000_0000_0040_0000 + 64'(i * 4));

        // R6: must-be-zero bit set
        for (int c = 0; c < 8; c++)
            step(1'b1, mk(2'b00, 1'b1, 1'b1, 3'(c), 3'b011, 1'b1, 16'h0004),
                 vals[c], 64'h2000);

        // R7: displacement polarity and wrap of the address
        for (int k = 0; k < 6; k++) begin
            step(1'b1, mk(2'b00, 1'b0, 1'b0, 3'd7, 3'b011, 1'b0, disps[k]),
                 64'd0, 64'hFFFF_FFFF_FFFF_FFF0);
            step(1'b1, mk(2'b00, 1'b0, 1'b0, 3'd1, 3'b011, 1'b0, disps[k]),
                 64'd0, 64'd8);
        end

        // R3: foreign formats, wrong sub-opcode, idle cycles
        for (int f = 1; f < 4; f++)
            step(1'b1, mk(2'(f), 1'b1, 1'b0, 3'd1, 3'b011, 1'b1, 16'h0100), 64'd0, 64'h3000);
        for (int o = 0; o < 8; o++)
            if (o != 3)
                step(1'b1, mk(2'b00, 1'b1, 1'b0, 3'd0, 3'(o), 1'b1, 16'h0100), 64'd0, 64'h3000);
        step(1'b0, mk(2'b00, 1'b1, 1'b0, 3'd1, 3'b011, 1'b1, 16'h0100), 64'd0, 64'h3000);
        step(1'b0, 32'h0, 64'd7, 64'h0);

        // mixed random words
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            logic [63:0] r;
            w = $urandom();
            if (n % 2 == 0) w[31:30] = 2'b00;
            if (n % 3 != 0) w[24:22] = 3'b011;
            if (n % 4 != 0) w[28] = 1'b0;
            r = {$urandom(), $urandom()};
            if (n % 5 == 0) r = '0;
            step(n % 7 != 6, w, r, {$urandom(), $urandom()});
        end
        step(1'b0, 32'h0, 64'd0, 64'd0);
        @(negedge clk);
        compare_now();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule